// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction now in the execute stage of a five-stage in-order pipeline, where each of its two ALU operands should come from. It compares both source register numbers against the destination register and write flag of the two younger results still in flight. One result sits in the memory-stage register and the other in the write-back-stage register. A match sends that result around the register file, so an instruction that depends on the one just ahead of it does not have to wait.

The unit is purely combinational. It returns a 2-bit select code for each operand and drives the two operand buses itself. The second operand has one more choice, the sign-extended immediate used by loads and stores, picked by a separate operand-source input. Register 31 reads as zero and is never forwarded. When both in-flight results target the same source register, the younger one in the memory stage wins.

Top module: `operand_fwd_unit`

## Requirements
- R1: If the memory-stage write flag is set, its destination is not 31 and it equals a source register, that operand's select code is 2'b10 and its bus carries `exmem_data`.
- R2: If the write-back-stage write flag is set, its destination is not 31 and it equals a source register, and R1 does not apply to that operand, the select code is 2'b01 and the bus carries `memwb_data`.
- R3: When both stages match the same source register, the memory-stage result is used (code 2'b10).
- R4: A source register equal to 31 always gets code 2'b00 and the register-file value, whatever the in-flight destinations are.
- R5: A stage whose write flag is clear neither forwards nor blocks forwarding from the other stage.
- R6: With no valid match, the code is 2'b00 and the bus carries the register-file value. Code 2'b11 is never produced.
- R7: The second operand follows the same rules as the first, on its own, using the second source register.
- R8: With `alu_src` high, `alu_in2` equals `imm_data`, and `fwd_sel2` still shows the forwarding decision.
- R9: With `alu_src` low, `alu_in2` equals the forwarded or register-file value that `fwd_sel2` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | 5 | First source register number of the execute-stage instruction |
| ex_src2 | input | 5 | Second source register number of the execute-stage instruction |
| exmem_wen | input | 1 | Memory-stage result will be written to a register |
| exmem_dst | input | 5 | Memory-stage destination register |
| memwb_wen | input | 1 | Write-back-stage result will be written to a register |
| memwb_dst | input | 5 | Write-back-stage destination register |
| alu_src | input | 1 | 1: second ALU input takes the immediate |
| rf_data1 | input | 32 | Register-file value for the first source |
| rf_data2 | input | 32 | Register-file value for the second source |
| exmem_data | input | 32 | Result held in the memory stage |
| memwb_data | input | 32 | Result held in the write-back stage |
| imm_data | input | 32 | Sign-extended immediate |
| fwd_sel1 | output | 2 | First operand select: 00 register file, 01 write-back, 10 memory stage |
| fwd_sel2 | output | 2 | Second operand select, same encoding |
| alu_in1 | output | 32 | First ALU operand |
| alu_in2 | output | 32 | Second ALU operand |

## Verification
The stimulus covers several patterns, and each one separates one rule from its neighbours:
- A match in the memory stage only, and a match in the write-back stage only, show that each path works.
- A match in both stages at once exposes a wrong priority.
- A write-back match beside a memory-stage match on a different register shows that blocking applies per register.
- Matches on register 31 fail a zero-register guard that is missing or has the wrong sense.
- A matching destination with its write flag clear catches a stage that forwards, or blocks, without its enable.
- The immediate cases show that the operand-source choice changes the bus and leaves the code alone.
- A sweep of every register number through the memory-stage match checks the comparator on each encoding.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FSEL_RF  = 2'b00,
        FSEL_WB  = 2'b01,
        FSEL_MEM = 2'b10
    } fsel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [AW-1:0] src,
    input  logic          exmem_wen,
    input  logic [AW-1:0] exmem_dst,
    input  logic          memwb_wen,
    input  logic [AW-1:0] memwb_dst,
    output logic [1:0]    sel
);
    localparam logic [AW-1:0] ZR = AW'(ZERO_REG);

    typedef struct packed {
        logic  hit_mem;
        logic  hit_wb;
        fsel_e sel;
    } match_t;

    match_t match_d;

    always_comb begin
        match_d.hit_mem = exmem_wen && (exmem_dst != ZR) && (exmem_dst == src);
        match_d.hit_wb  = memwb_wen && (memwb_dst != ZR) && (memwb_dst == src);
        if (match_d.hit_mem)
            match_d.sel = FSEL_MEM;
        else if (match_d.hit_wb)
            match_d.sel = FSEL_WB;
        else
            match_d.sel = FSEL_RF;
    end

    assign sel = match_d.sel;

    always_comb begin
        AST_NO_CODE3: assert (sel != 2'b11); // R6
        AST_ZERO_SRC: assert ((src != ZR) || (sel == 2'b00)); // R4
        AST_WEN_GATES: assert (exmem_wen || memwb_wen || (sel == 2'b00)); // R5
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] mem_val,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DW-1:0] val;
    } mux_t;

    mux_t mux_d;

    always_comb begin
        unique case (sel)
            FSEL_WB:  mux_d.val = wb_val;
            FSEL_MEM: mux_d.val = mem_val;
            default:  mux_d.val = rf_val;
        endcase
    end

    assign dout = mux_d.val;
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 32,
    parameter int ZERO_REG = 31
) (
    input  logic [AW-1:0] ex_src1,
    input  logic [AW-1:0] ex_src2,
    input  logic          exmem_wen,
    input  logic [AW-1:0] exmem_dst,
    input  logic          memwb_wen,
    input  logic [AW-1:0] memwb_dst,
    input  logic          alu_src,
    input  logic [DW-1:0] rf_data1,
    input  logic [DW-1:0] rf_data2,
    input  logic [DW-1:0] exmem_data,
    input  logic [DW-1:0] memwb_data,
    input  logic [DW-1:0] imm_data,
    output logic [1:0]    fwd_sel1,
    output logic [1:0]    fwd_sel2,
    output logic [DW-1:0] alu_in1,
    output logic [DW-1:0] alu_in2
);
    localparam int NOPS = 2;

    logic [AW-1:0] src_v [NOPS];
    logic [DW-1:0] rf_v  [NOPS];
    logic [1:0]    sel_v [NOPS];
    logic [DW-1:0] fwd_v [NOPS];

    assign src_v[0] = ex_src1;
    assign src_v[1] = ex_src2;
    assign rf_v[0]  = rf_data1;
    assign rf_v[1]  = rf_data2;

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fwd_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_match (
            .src       (src_v[i]),
            .exmem_wen (exmem_wen),
            .exmem_dst (exmem_dst),
            .memwb_wen (memwb_wen),
            .memwb_dst (memwb_dst),
            .sel       (sel_v[i])
        );
        fwd_mux #(.DW(DW)) u_mux (
            .sel     (sel_v[i]),
            .rf_val  (rf_v[i]),
            .wb_val  (memwb_data),
            .mem_val (exmem_data),
            .dout    (fwd_v[i])
        );
    end

    typedef struct packed {
        logic [DW-1:0] in1;
        logic [DW-1:0] in2;
    } opnd_t;

    opnd_t opnd_d;

    always_comb begin
        opnd_d.in1 = fwd_v[0];
        opnd_d.in2 = alu_src ? imm_data : fwd_v[1];
    end

    assign fwd_sel1 = sel_v[0];
    assign fwd_sel2 = sel_v[1];
    assign alu_in1  = opnd_d.in1;
    assign alu_in2  = opnd_d.in2;

    always_comb begin
        AST_MEM_DATA1: assert ((fwd_sel1 != 2'b10) || (alu_in1 == exmem_data)); // R1
        AST_WB_DATA1: assert ((fwd_sel1 != 2'b01) || (alu_in1 == memwb_data)); // R2
        AST_IMM_PASS: assert (!alu_src || (alu_in2 == imm_data)); // R8
        AST_FWD2_PASS: assert (alu_src || (fwd_sel2 != 2'b10) || (alu_in2 == exmem_data)); // R9
    end
endmodule

// File: tb/sim_operand_fwd_unit.sv
module sim_operand_fwd_unit;
    localparam logic [31:0] RF1 = 32'hA1A1_0001, RF2 = 32'hB2B2_0002;
    localparam logic [31:0] EXD = 32'hC3C3_0003, WBD = 32'hD4D4_0004, IMM = 32'hE5E5_0005;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0] ex_src1, ex_src2, exmem_dst, memwb_dst;
    logic exmem_wen, memwb_wen, alu_src;
    logic [1:0] fwd_sel1, fwd_sel2;
    logic [31:0] alu_in1, alu_in2;
    int total = 0, bad = 0;

    operand_fwd_unit u0 (
        .ex_src1(ex_src1), .ex_src2(ex_src2), .exmem_wen(exmem_wen), .exmem_dst(exmem_dst),
        .memwb_wen(memwb_wen), .memwb_dst(memwb_dst), .alu_src(alu_src),
        .rf_data1(RF1), .rf_data2(RF2), .exmem_data(EXD), .memwb_data(WBD), .imm_data(IMM),
        .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2), .alu_in1(alu_in1), .alu_in2(alu_in2)
    );

    typedef struct packed {
        logic [4:0] s1, s2;
        logic       ew;
        logic [4:0] ed;
        logic       ww;
        logic [4:0] wd;
        logic       as;
        logic [1:0] e1, e2;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  1'b1, 5'd3,  1'b1, 5'd4,  1'b0, 2'b00, 2'b00}, // R6 no match
        '{5'd5,  5'd2,  1'b1, 5'd5,  1'b0, 5'd0,  1'b0, 2'b10, 2'b00}, // R1
        '{5'd1,  5'd7,  1'b0, 5'd7,  1'b1, 5'd7,  1'b0, 2'b00, 2'b01}, // R2 R5 R7
        '{5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  1'b0, 2'b10, 2'b10}, // R3
        '{5'd4,  5'd6,  1'b1, 5'd6,  1'b1, 5'd4,  1'b0, 2'b01, 2'b10}, // R2 R7
        '{5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 5'd31, 1'b0, 2'b00, 2'b00}, // R4
        '{5'd3,  5'd3,  1'b0, 5'd3,  1'b1, 5'd3,  1'b0, 2'b01, 2'b01}, // R5
        '{5'd3,  5'd3,  1'b0, 5'd0,  1'b0, 5'd3,  1'b0, 2'b00, 2'b00}, // R5
        '{5'd8,  5'd8,  1'b1, 5'd8,  1'b0, 5'd0,  1'b1, 2'b10, 2'b10}, // R8
        '{5'd2,  5'd10, 1'b0, 5'd0,  1'b1, 5'd10, 1'b1, 2'b00, 2'b01}, // R8
        '{5'd0,  5'd0,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'b10, 2'b10}, // R1 R9
        '{5'd31, 5'd12, 1'b1, 5'd31, 1'b1, 5'd12, 1'b0, 2'b00, 2'b01}  // R4 R9
    };

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'b10) ? EXD : (s == 2'b01) ? WBD : rf;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        ex_src1 = v.s1; ex_src2 = v.s2; exmem_wen = v.ew; exmem_dst = v.ed;
        memwb_wen = v.ww; memwb_dst = v.wd; alu_src = v.as;
        #2;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ex_src1 = 5'd1; ex_src2 = 5'd1; exmem_wen = 1'b0; exmem_dst = 5'd1;
        memwb_wen = 1'b0; memwb_dst = 5'd1; alu_src = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // reset-state pattern: no writes pending, R5 R6
        chk("R6 reset sel1", 32'(fwd_sel1), 32'd0);
        chk("R6 reset sel2", 32'(fwd_sel2), 32'd0);
        chk("R6 reset in1", alu_in1, RF1);
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            chk("R1/R2/R3/R4 sel1", 32'(fwd_sel1), 32'(VECS[i].e1));
            chk("R7 sel2", 32'(fwd_sel2), 32'(VECS[i].e2));
            chk("R1/R2/R6 in1", alu_in1, pick(VECS[i].e1, RF1));
            chk(VECS[i].as ? "R8 in2" : "R9 in2", alu_in2,
                VECS[i].as ? IMM : pick(VECS[i].e2, RF2));
        end
        // sweep every register number through a memory-stage match: R1 R4
        for (int r = 0; r < 32; r++) begin
            apply('{5'(r), 5'(31 - r), 1'b1, 5'(r), 1'b1, 5'(31 - r), 1'b0, 2'b00, 2'b00});
            chk("R1 sweep sel1", 32'(fwd_sel1), (r == 31) ? 32'd0 : 32'd2);
            chk("R4 sweep sel2", 32'(fwd_sel2), (r == 0) ? 32'd0 : 32'd1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule